// File: doc/BRIEF.md
# Fixed-Size Bulk Command Packet Parser

This block sits behind a bulk byte pipe and turns a continuous stream of 512-byte command packets into decoded fields. Bytes arrive over a valid/ready byte interface. A running byte position splits every packet into three parts: a six-byte header, a 505-byte payload window and a single trailing checksum byte. The header holds a three-level command code, a little-endian payload length and one reserved byte. The first command level names the direction and role of the packet: write, write response, read or read response. The second level names a function group and the third refines it.

Once the header is complete, the block publishes the command fields, the length and a direction flag. It forwards each payload byte with a strobe and its index inside the payload window. After the checksum byte it gives exactly one verdict pulse, marked success or failure. A verdict is a failure when the checksum does not match, when the declared length is too large, or when the first command level is not a known code. Packets may follow one another with no idle cycle between them. An abort input throws away a packet that is only partly received.

Top module: `bulk_pkt_parser`

## Requirements
- R1: While reset is active, and in the first cycle after reset, `hdr_valid_o`, `pay_valid_o` and `done_o` are low. `in_ready_o` is low during reset and high from the first clock edge after reset is released.
- R2: The bytes at packet positions 0, 1 and 2 appear on `cmd1_o`, `cmd2_o` and `cmd3_o`. Position 3 is the low byte and position 4 the high byte of `len_o`. Position 5 has no effect. All of these are published together with a one-cycle `hdr_valid_o` pulse in the cycle after the byte at position 5 is accepted, and they hold until the next header is complete.
- R3: `is_write_o` is 1 when `cmd1_o` is 0x01 (write) or 0x02 (write response). It is 0 for 0x03 (read), 0x04 (read response) and any other code.
- R4: Each byte accepted at positions 6 to 510 is presented on `pay_data_o` with `pay_valid_o` high in the following cycle. Its `pay_idx_o` equals the position minus 6, so the indices run 0 to 504.
- R5: In the cycle after the byte at position 511 is accepted, `done_o` pulses for one cycle. `ok_o` is 1 when the 8-bit modulo sum of positions 0 to 510 equals byte 511, the length is at most 505 and CMD1 is one of 0x01 to 0x04.
- R6: A checksum byte that differs from the 8-bit sum gives `done_o` with `ok_o` = 0.
- R7: A declared length above 505 gives `ok_o` = 0. A length of exactly 505 is accepted.
- R8: A CMD1 value outside 0x01 to 0x04 gives `ok_o` = 0.
- R9: The byte that follows position 511 in the same stream is treated as position 0 of a new packet. No idle cycle is needed between packets.
- R10: Cycles with `in_valid_i` low advance nothing and produce no output event. The packet result is the same as for a packet sent with no gaps.
- R11: When `abort_i` is high, the byte presented in that cycle is discarded. The partial packet yields no further payload, header or verdict events, and the next accepted byte is position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_i | input | 1 | Drop the partial packet and restart at position 0 |
| in_valid_i | input | 1 | Input byte is present |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Parser accepts a byte this cycle |
| hdr_valid_o | output | 1 | One-cycle pulse: header fields updated |
| cmd1_o | output | 8 | First command level (direction and role) |
| cmd2_o | output | 8 | Function group |
| cmd3_o | output | 8 | Refinement within the group |
| len_o | output | 16 | Declared payload length |
| is_write_o | output | 1 | Packet is a write or a write response |
| pay_valid_o | output | 1 | Payload byte strobe |
| pay_data_o | output | 8 | Payload byte |
| pay_idx_o | output | 9 | Index of the byte within the payload window |
| done_o | output | 1 | One-cycle verdict pulse at packet end |
| ok_o | output | 1 | Verdict: 1 success, 0 failure (valid with done_o) |

## Verification
Every result comes from a single register stage. A payload strobe, the header pulse and the verdict each appear exactly one cycle after the byte that causes them is accepted. The driver task therefore queues the expected event in the same cycle that it presents the byte. The monitor samples on the falling edge of the following cycle, pops the oldest queued event and compares it in full. Any output pulse that finds the queue empty is counted as a failure, and so is any event that is still queued at the end of the run. This covers the gapped stream, the abort and the back-to-back case without any per-test timing code.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

    localparam logic [7:0] OP_WRITE    = 8'h01;
    localparam logic [7:0] OP_WRITE_RS = 8'h02;
    localparam logic [7:0] OP_READ     = 8'h03;
    localparam logic [7:0] OP_READ_RS  = 8'h04;

    // header byte positions; the decoder depends on this order
    localparam int POS_OP     = 0;
    localparam int POS_GROUP  = 1;
    localparam int POS_SUB    = 2;
    localparam int POS_LEN_LO = 3;
    localparam int POS_LEN_HI = 4;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  group;
        logic [7:0]  sub;
        logic [15:0] len;
    } hdr_t;

    function automatic logic op_known(input logic [7:0] op);
        return (op == OP_WRITE) || (op == OP_WRITE_RS) ||
               (op == OP_READ)  || (op == OP_READ_RS);
    endfunction

    function automatic logic op_writes(input logic [7:0] op);
        return (op == OP_WRITE) || (op == OP_WRITE_RS);
    endfunction

endpackage

// File: rtl/bpp_byte_counter.sv
module bpp_byte_counter #(
    parameter int PKT_BYTES = 512,
    parameter int CW        = $clog2(PKT_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort_i,
    input  logic          step_i,
    output logic [CW-1:0] pos_o,
    output logic          last_o
);

    localparam logic [CW-1:0] LAST_POS = CW'(PKT_BYTES - 1);

    typedef struct packed {
        logic [CW-1:0] pos;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (abort_i) begin
            st_d.pos = '0;
        end else if (step_i) begin
            if (st_q.pos == LAST_POS) st_d.pos = '0;
            else                      st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_o  = st_q.pos;
    assign last_o = (st_q.pos == LAST_POS);

endmodule

// File: rtl/bpp_hdr_decoder.sv
module bpp_hdr_decoder
    import bpp_pkg::*;
#(
    parameter int HDR_BYTES = 6,
    parameter int PAY_BYTES = 505,
    parameter int CW        = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [CW-1:0] pos_i,
    input  logic [7:0]    data_i,
    output hdr_t          hdr_o,
    output logic          legal_o,
    output logic          is_write_o,
    output logic          hdr_valid_o
);

    localparam logic [CW-1:0] P_OP     = CW'(POS_OP);
    localparam logic [CW-1:0] P_GROUP  = CW'(POS_GROUP);
    localparam logic [CW-1:0] P_SUB    = CW'(POS_SUB);
    localparam logic [CW-1:0] P_LEN_LO = CW'(POS_LEN_LO);
    localparam logic [CW-1:0] P_LEN_HI = CW'(POS_LEN_HI);
    localparam logic [CW-1:0] P_CLOSE  = CW'(HDR_BYTES - 1);
    localparam logic [15:0]   LEN_MAX  = 16'(PAY_BYTES);

    typedef struct packed {
        hdr_t shadow;   // fields while the header is arriving
        hdr_t pub;      // fields of the last complete header
        logic legal;
        logic wr;
        logic pulse;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (step_i) begin
            if (pos_i == P_OP)     st_d.shadow.op        = data_i;
            if (pos_i == P_GROUP)  st_d.shadow.group     = data_i;
            if (pos_i == P_SUB)    st_d.shadow.sub       = data_i;
            if (pos_i == P_LEN_LO) st_d.shadow.len[7:0]  = data_i;
            if (pos_i == P_LEN_HI) st_d.shadow.len[15:8] = data_i;
            if (pos_i == P_CLOSE) begin
                st_d.pub   = st_q.shadow;
                st_d.legal = op_known(st_q.shadow.op) &&
                             (st_q.shadow.len <= LEN_MAX);
                st_d.wr    = op_writes(st_q.shadow.op);
                st_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_o       = st_q.pub;
    assign legal_o     = st_q.legal;
    assign is_write_o  = st_q.wr;
    assign hdr_valid_o = st_q.pulse;

endmodule

// File: rtl/bpp_sum_check.sv
module bpp_sum_check #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic [CW-1:0] pos_i,
    input  logic [7:0]    data_i,
    output logic          match_o
);

    typedef struct packed {
        logic [7:0] acc;
    } sum_st_t;

    sum_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (pos_i == '0) st_d.acc = data_i;
            else             st_d.acc = st_q.acc + data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // compared against the byte at the closing position
    assign match_o = (st_q.acc == data_i);

endmodule

// File: rtl/bulk_pkt_parser.sv
module bulk_pkt_parser
    import bpp_pkg::*;
#(
    parameter int PKT_BYTES = 512,
    parameter int HDR_BYTES = 6,
    parameter int PAY_BYTES = PKT_BYTES - HDR_BYTES - 1,
    parameter int CW        = $clog2(PKT_BYTES),
    parameter int IW        = $clog2(PAY_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort_i,
    input  logic          in_valid_i,
    input  logic [7:0]    in_data_i,
    output logic          in_ready_o,
    output logic          hdr_valid_o,
    output logic [7:0]    cmd1_o,
    output logic [7:0]    cmd2_o,
    output logic [7:0]    cmd3_o,
    output logic [15:0]   len_o,
    output logic          is_write_o,
    output logic          pay_valid_o,
    output logic [7:0]    pay_data_o,
    output logic [IW-1:0] pay_idx_o,
    output logic          done_o,
    output logic          ok_o
);

    localparam logic [CW-1:0] PAY_FIRST = CW'(HDR_BYTES);
    localparam logic [CW-1:0] PAY_END   = CW'(HDR_BYTES + PAY_BYTES);

    typedef struct packed {
        logic          ready;
        logic          pay_valid;
        logic [7:0]    pay_data;
        logic [IW-1:0] pay_idx;
        logic          done;
        logic          ok;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          step;
    logic [CW-1:0] pos;
    logic          last;
    logic          sum_match;
    logic          hdr_legal;
    hdr_t          hdr;

    assign step = in_valid_i && st_q.ready && !abort_i;

    bpp_byte_counter #(.PKT_BYTES(PKT_BYTES), .CW(CW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort_i(abort_i),
        .step_i (step),
        .pos_o  (pos),
        .last_o (last)
    );

    bpp_hdr_decoder #(.HDR_BYTES(HDR_BYTES), .PAY_BYTES(PAY_BYTES), .CW(CW)) u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .pos_i      (pos),
        .data_i     (in_data_i),
        .hdr_o      (hdr),
        .legal_o    (hdr_legal),
        .is_write_o (is_write_o),
        .hdr_valid_o(hdr_valid_o)
    );

    bpp_sum_check #(.CW(CW)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .pos_i  (pos),
        .data_i (in_data_i),
        .match_o(sum_match)
    );

    always_comb begin
        st_d           = st_q;
        st_d.ready     = 1'b1;
        st_d.pay_valid = 1'b0;
        st_d.done      = 1'b0;
        if (step && (pos >= PAY_FIRST) && (pos < PAY_END)) begin
            st_d.pay_valid = 1'b1;
            st_d.pay_data  = in_data_i;
            st_d.pay_idx   = IW'(pos - PAY_FIRST);
        end
        if (step && last) begin
            st_d.done = 1'b1;
            st_d.ok   = sum_match && hdr_legal;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready_o  = st_q.ready;
    assign pay_valid_o = st_q.pay_valid;
    assign pay_data_o  = st_q.pay_data;
    assign pay_idx_o   = st_q.pay_idx;
    assign done_o      = st_q.done;
    assign ok_o        = st_q.ok;
    assign cmd1_o      = hdr.op;
    assign cmd2_o      = hdr.group;
    assign cmd3_o      = hdr.sub;
    assign len_o       = hdr.len;

endmodule

// File: rtl/bulk_pkt_parser_chk.sv
module bulk_pkt_parser_chk
    import bpp_pkg::*;
#(
    parameter int PAY_BYTES = 505,
    parameter int IW        = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          abort_i,
    input logic          in_ready_o,
    input logic          hdr_valid_o,
    input logic [7:0]    cmd1_o,
    input logic [15:0]   len_o,
    input logic          is_write_o,
    input logic          pay_valid_o,
    input logic [IW-1:0] pay_idx_o,
    input logic          done_o,
    input logic          ok_o
);

    // R4
    idx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid_o |-> (pay_idx_o < IW'(PAY_BYTES)));

    // R4
    idx_increments_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid_o && $past(pay_valid_o)) |-> (pay_idx_o == $past(pay_idx_o) + 1'b1));

    // R11
    abort_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !(done_o || pay_valid_o || hdr_valid_o));

    // R9
    events_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, pay_valid_o, hdr_valid_o}));

    // R7
    ok_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> (len_o <= 16'(PAY_BYTES)));

    // R8
    ok_known_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ok_o) |-> op_known(cmd1_o));

    // R3
    dir_matches_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> (is_write_o == ((cmd1_o == OP_WRITE) || (cmd1_o == OP_WRITE_RS))));

    // R2
    hdr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |=> !hdr_valid_o);

    // R1
    ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready_o);

endmodule

bind bulk_pkt_parser bulk_pkt_parser_chk #(.PAY_BYTES(PAY_BYTES), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_i    (abort_i),
    .in_ready_o (in_ready_o),
    .hdr_valid_o(hdr_valid_o),
    .cmd1_o     (cmd1_o),
    .len_o      (len_o),
    .is_write_o (is_write_o),
    .pay_valid_o(pay_valid_o),
    .pay_idx_o  (pay_idx_o),
    .done_o     (done_o),
    .ok_o       (ok_o)
);

// File: tb/bulk_pkt_parser_test.sv
module bulk_pkt_parser_test;

    localparam int NB = 512;
    localparam int NH = 6;
    localparam int NP = 505;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = 8'h00;
    logic        in_ready_o, hdr_valid_o, is_write_o, pay_valid_o, done_o, ok_o;
    logic [7:0]  cmd1_o, cmd2_o, cmd3_o, pay_data_o;
    logic [15:0] len_o;
    logic [8:0]  pay_idx_o;

    always #10 clk = ~clk;

    bulk_pkt_parser uut (
        .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .hdr_valid_o(hdr_valid_o), .cmd1_o(cmd1_o), .cmd2_o(cmd2_o), .cmd3_o(cmd3_o),
        .len_o(len_o), .is_write_o(is_write_o),
        .pay_valid_o(pay_valid_o), .pay_data_o(pay_data_o), .pay_idx_o(pay_idx_o),
        .done_o(done_o), .ok_o(ok_o)
    );

    typedef struct {
        int          kind;   // 0 header, 1 payload, 2 verdict
        logic [63:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    bit   mon_on = 1'b0;
    int   cyc = 0;

    task automatic check(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: outputs settle after posedge, sampled at negedge
    always @(negedge clk) begin
        if (mon_on) begin
            int          k;
            logic [63:0] act;
            k = -1;
            if (hdr_valid_o) begin k = 0; act = {23'd0, is_write_o, cmd1_o, cmd2_o, cmd3_o, len_o}; end
            if (pay_valid_o) begin k = 1; act = {47'd0, pay_idx_o, pay_data_o}; end
            if (done_o)      begin k = 2; act = {63'd0, ok_o}; end
            if (k >= 0) begin
                if (q.size() == 0) begin
                    check(1'b0, "R11 unexpected event", 64'(k), 64'hFFFF);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check((e.kind == k) && (e.val == act), e.req,
                          {56'(k), act[7:0]} ^ 64'd0 | (act << 8), {56'(e.kind), e.val[7:0]} | (e.val << 8));
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog", 64'(cyc), 64'd100000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic drive(input logic [7:0] b);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b0;
        end
    endtask

    // builds a packet, queues expected events, drives stop_at bytes
    task automatic send_pkt(input logic [7:0] c1, input logic [7:0] c2, input logic [7:0] c3,
                            input logic [15:0] len, input logic [7:0] seed, input bit bad_sum,
                            input int gap_every, input int stop_at, input string tag);
        logic [7:0] b [NB];
        logic [7:0] sum;
        bit         wr, good;
        b[0] = c1; b[1] = c2; b[2] = c3; b[3] = len[7:0]; b[4] = len[15:8]; b[5] = seed ^ 8'hC3;
        for (int i = NH; i < NB - 1; i++) b[i] = seed + 8'(i * 7);
        sum = 8'h00;
        for (int i = 0; i < NB - 1; i++) sum = sum + b[i];
        b[NB-1] = bad_sum ? (sum ^ 8'h5A) : sum;
        wr   = (c1 == 8'h01) || (c1 == 8'h02);
        good = (c1 >= 8'h01) && (c1 <= 8'h04) && (len <= 16'(NP)) && !bad_sum;
        for (int i = 0; i < stop_at; i++) begin
            if (gap_every > 0 && (i % gap_every) == gap_every - 1) idle(2);
            drive(b[i]);
            if (i == NH - 1) q.push_back('{0, {23'd0, wr, c1, c2, c3, len}, {"R2 R3 ", tag}});
            if (i >= NH && i < NB - 1) q.push_back('{1, {47'd0, 9'(i - NH), b[i]}, {"R4 ", tag}});
            if (i == NB - 1) q.push_back('{2, {63'd0, good}, {"R5 ", tag}});
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!in_ready_o && !hdr_valid_o && !pay_valid_o && !done_o, "R1 in reset",
              {in_ready_o, hdr_valid_o, pay_valid_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o, "R1 ready after reset", in_ready_o, 1);
        check(!hdr_valid_o && !pay_valid_o && !done_o, "R1 quiet after reset",
              {hdr_valid_o, pay_valid_o, done_o}, 64'd0);
        mon_on = 1'b1;

        // R5 R7: write, maximum legal length, good sum
        send_pkt(8'h01, 8'h10, 8'h21, 16'd505, 8'h11, 1'b0, 0, NB, "R7 max len ok");
        // R9: read packet immediately after, no gap
        send_pkt(8'h03, 8'h22, 8'h05, 16'd10, 8'h3C, 1'b0, 0, NB, "R9 back-to-back read");
        idle(3);
        // R10: write response with valid gaps
        send_pkt(8'h02, 8'h07, 8'h7F, 16'd200, 8'hA5, 1'b0, 3, NB, "R10 gapped");
        idle(2);
        // R6: read response with corrupt checksum
        send_pkt(8'h04, 8'h01, 8'h02, 16'd4, 8'h5E, 1'b1, 0, NB, "R6 bad sum");
        idle(2);
        // R7: length one over the limit
        send_pkt(8'h01, 8'h33, 8'h44, 16'd506, 8'h09, 1'b0, 0, NB, "R7 len over");
        idle(2);
        // R8: unknown CMD1 code, direction flag 0 (R3)
        send_pkt(8'h07, 8'h02, 8'h03, 16'd1, 8'h77, 1'b0, 0, NB, "R8 unknown op");
        idle(2);

        // R11: partial packet, then abort with a byte present
        send_pkt(8'h01, 8'h55, 8'h66, 16'd20, 8'h42, 1'b0, 0, 100, "R11 partial");
        @(negedge clk);
        abort_i    = 1'b1;
        in_valid_i = 1'b1;
        in_data_i  = 8'hEE;
        @(negedge clk);
        abort_i    = 1'b0;
        in_valid_i = 1'b0;
        check(!pay_valid_o && !done_o && !hdr_valid_o, "R11 abort cycle silent",
              {pay_valid_o, done_o, hdr_valid_o}, 64'd0);
        idle(4);
        check(q.size() == 0, "R11 no events after abort", 64'(q.size()), 64'd0);
        send_pkt(8'h03, 8'h09, 8'h0A, 16'd33, 8'h6B, 1'b0, 0, NB, "R11 restart");
        idle(4);

        check(q.size() == 0, "R9 all expected events seen", 64'(q.size()), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule